// File: doc/BRIEF.md
# Buffered Serial Peripheral Port

This block is an 8-bit serial peripheral port attached to a small processor's register bus. Software places a byte in a transmit holding register and sets a start bit. The block moves that byte into a shift register and exchanges it with the far end, most significant bit first, sending and receiving at the same time. When the eighth bit has moved, the received byte goes into a separate receive holding register. A receive-full flag and a sticky interrupt flag are then raised.

The port runs as the clock master or as a clock slave. As master it drives the serial clock from the system clock, divided by a power of two that a 3-bit rate field selects. As slave it follows an external serial clock, and an active-low select input decides whether it takes part. An edge-select bit fixes the idle level of the serial clock and which of its edges samples. Output-enable signals let the chip put the clock and data pins into high impedance.

The register map uses three addresses. CTRL is at 0: bit 0 is start/busy, bit 1 is edge select, bits 4:2 are the rate. DATA is at 1: a write goes to the transmit buffer and a read returns the receive buffer. STAT is at 2: bit 0 is receive-full, bit 1 is interrupt, bit 2 is overrun and bit 3 is busy.

Top module: `spi_port`

## Requirements
- R1: Each transfer moves exactly 8 bits in each direction at once, most significant bit first. The byte sampled from `sdi` appears at DATA (address 1). The transmit buffer leaves on `sdo`.
- R2: Writing CTRL with bit 0 set while the port is idle loads the transmit buffer into the shift register and starts a transfer. CTRL bit 0 and STAT bit 3 read 1 until the eighth bit completes, then return to 0. Any CTRL write made during a transfer has no effect.
- R3: When a byte completes, the receive buffer takes the received byte. STAT bit 0 (receive-full), STAT bit 1 (interrupt) and the `irq` pin become 1.
- R4: A read of DATA clears STAT bit 0.
- R5: A DATA write made while a transfer is in progress is ignored. The transmit buffer keeps its earlier contents.
- R6: A rate code r from 0 to 6 (CTRL bits 4:2) selects master mode. In this mode the serial clock period is 2^(r+1) system clocks.
- R7: Rate code 7 selects slave mode. Bits shift on edges of `sck_i` and `sck_oe` is 0. In master mode `sck_oe` is 1.
- R8: When CTRL bit 1 is 0, the serial clock idles low, rising edges sample and falling edges shift. When it is 1, the clock idles high, falling edges sample and rising edges shift. Between transfers, `sck_o` rests at the idle level.
- R9: In slave mode, `sdo_oe` is 0 while `ss_n` is high. The bit count also restarts while `ss_n` is high, so a byte completes only after 8 bits received after select.
- R10: The interrupt flag holds until a STAT write with bit 1 equal to 0. A byte that completes while receive-full is set overwrites the receive buffer and sets STAT bit 2. A STAT write with bit 2 equal to 0 clears that bit.
- R11: After reset, CTRL and STAT read 0, `irq` is 0, the port is master at rate code 0, and `sck_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; needed only for the side effect of a DATA read |
| bus_addr | input | 2 | Register select: 0 CTRL, 1 DATA, 2 STAT |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Sticky interrupt flag |
| sck_i | input | 1 | External serial clock (slave mode) |
| sck_o | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the serial data out pin |
| ss_n | input | 1 | Active-low select for slave mode |

## Verification
The hardest case to reach from the ports is a slave that is deselected in the middle of a byte. The bench has to show that the bit count restarted and did not simply pause. It clocks three bits with select low, raises `ss_n` long enough for the synchronizer to see it, then gives five more bits. At that point a paused counter would already have finished, but a restarted one has not, so busy must still read 1 with no interrupt. Three further bits must then finish the byte.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam int RATE_W = 3;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_DATA = 2'd1,
    ADR_STAT = 2'd2
  } reg_sel_e;

  // CTRL field positions (software visible)
  localparam int CB_GO   = 0;
  localparam int CB_EDGE = 1;
  localparam int CB_RATE = 2;
  // STAT bit positions
  localparam int SB_FULL = 0;
  localparam int SB_IRQ  = 1;
  localparam int SB_OVR  = 2;
  localparam int SB_BUSY = 3;
endpackage

// File: rtl/spi_rate_div.sv
`timescale 1ns/1ps
module spi_rate_div #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int DIV_W = (1 << RW) - 2;

  // half-period in system clocks minus one: 2^code - 1
  function automatic logic [DIV_W-1:0] half_limit(input logic [RW-1:0] code);
    logic [DIV_W-1:0] ones;
    ones = '1;
    return ones >> (DIV_W - int'(code));
  endfunction

  logic [DIV_W-1:0] cnt_q;
  wire  [DIV_W-1:0] lim = half_limit(rate);

  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_sck_edges.sv
`timescale 1ns/1ps
module spi_sck_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic idle_lvl,
  input  logic busy,
  input  logic tick,
  input  logic sck_in,
  input  logic sel_n,
  output logic sck_drv,
  output logic lead,
  output logic trail,
  output logic desel
);
  // master: phase toggles on every divider tick; 0 means at idle level
  logic phase_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= 1'b0;
    else if (!busy)          phase_q <= 1'b0;
    else if (master && tick) phase_q <= ~phase_q;
  end
  assign sck_drv = idle_lvl ^ phase_q;

  // slave: external clock and select brought into the system clock domain
  logic sck_s1, sck_s2, sck_s3, ss_s1, ss_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sck_s1, sck_s2, sck_s3} <= '0;
      {ss_s1, ss_s2}           <= 2'b11;
    end else begin
      sck_s1 <= sck_in;
      sck_s2 <= sck_s1;
      sck_s3 <= sck_s2;
      ss_s1  <= sel_n;
      ss_s2  <= ss_s1;
    end
  end

  wire s_edge  = busy & ~ss_s2 & (sck_s2 ^ sck_s3);
  wire s_lead  = s_edge & (sck_s2 != idle_lvl);
  wire s_trail = s_edge & (sck_s2 == idle_lvl);
  wire m_lead  = busy & tick & ~phase_q;
  wire m_trail = busy & tick &  phase_q;

  assign lead  = master ? m_lead  : s_lead;
  assign trail = master ? m_trail : s_trail;
  assign desel = ~master & ss_s2;
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lead,
  input  logic          trail,
  input  logic          clr_cnt,
  input  logic          sdi,
  output logic          sdo,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] shreg_q;
  logic [CW-1:0] cnt_q;
  logic          rx_bit_q;

  assign sdo     = shreg_q[DW-1];
  assign rx_byte = {shreg_q[DW-2:0], rx_bit_q};
  assign done    = trail & ~clr_cnt & (cnt_q == CW'(DW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      rx_bit_q <= 1'b0;
    end else if (load) begin
      shreg_q <= load_data;
      cnt_q   <= '0;
    end else begin
      if (lead) rx_bit_q <= sdi;
      if (clr_cnt) cnt_q <= '0;
      else if (trail) cnt_q <= cnt_q + 1'b1;
      if (trail) shreg_q <= {shreg_q[DW-2:0], rx_bit_q};
    end
  end
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          ss_n
);
  logic [RW-1:0] rate_q;
  logic          edge_q, busy_q, rbf_q, irq_q, ovr_q;
  logic [DW-1:0] wbuf_q, rbuf_q;

  wire is_master = (rate_q != {RW{1'b1}});
  wire hit_ctrl  = (bus_addr == ADR_CTRL);
  wire hit_data  = (bus_addr == ADR_DATA);
  wire hit_stat  = (bus_addr == ADR_STAT);

  // named bus events
  wire ctrl_wr = bus_wr & hit_ctrl & ~busy_q;
  wire go      = ctrl_wr & bus_wdata[CB_GO];
  wire data_wr = bus_wr & hit_data & ~busy_q;
  wire data_rd = bus_rd & hit_data;
  wire stat_wr = bus_wr & hit_stat;

  wire          rate_tick, sck_lead, sck_trail, deselected, shift_done;
  wire [DW-1:0] rx_byte;

  spi_rate_div #(.RW(RW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_q & is_master), .rate(rate_q), .tick(rate_tick)
  );

  spi_sck_edges u_edges (
    .clk(clk), .rst_n(rst_n), .master(is_master), .idle_lvl(edge_q), .busy(busy_q),
    .tick(rate_tick), .sck_in(sck_i), .sel_n(ss_n), .sck_drv(sck_o),
    .lead(sck_lead), .trail(sck_trail), .desel(deselected)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(go), .load_data(wbuf_q), .lead(sck_lead),
    .trail(sck_trail), .clr_cnt(deselected), .sdi(sdi), .sdo(sdo),
    .done(shift_done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      edge_q <= 1'b0;
      busy_q <= 1'b0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      rbf_q  <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        edge_q <= bus_wdata[CB_EDGE];
        rate_q <= bus_wdata[CB_RATE +: RW];
      end
      if (go)              busy_q <= 1'b1;
      else if (shift_done) busy_q <= 1'b0;
      if (data_wr) wbuf_q <= bus_wdata;
      if (shift_done) rbuf_q <= rx_byte;
      if (shift_done)   rbf_q <= 1'b1;
      else if (data_rd) rbf_q <= 1'b0;
      if (shift_done)                         irq_q <= 1'b1;
      else if (stat_wr && !bus_wdata[SB_IRQ]) irq_q <= 1'b0;
      if (shift_done && rbf_q && !data_rd)    ovr_q <= 1'b1;
      else if (stat_wr && !bus_wdata[SB_OVR]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: begin
        bus_rdata[CB_GO]          = busy_q;
        bus_rdata[CB_EDGE]        = edge_q;
        bus_rdata[CB_RATE +: RW]  = rate_q;
      end
      ADR_DATA: bus_rdata = rbuf_q;
      ADR_STAT: begin
        bus_rdata[SB_FULL] = rbf_q;
        bus_rdata[SB_IRQ]  = irq_q;
        bus_rdata[SB_OVR]  = ovr_q;
        bus_rdata[SB_BUSY] = busy_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq    = irq_q;
  assign sck_oe = is_master;
  assign sdo_oe = is_master | ~ss_n;

  // R2: busy only falls through completion of the eighth bit
  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !shift_done |=> busy_q);
  // R3: completion raises both status flags
  a_r3_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |=> rbf_q && irq_q);
  // R4: a receive read with no simultaneous completion empties the flag
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !shift_done |=> !rbf_q);
  // R5: transmit buffer frozen during a transfer
  a_r5_wbuf_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(wbuf_q));
  // R8: master clock back at its idle level after the last bit
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done && is_master |=> sck_o == edge_q);
  // R10: completion onto an unread byte flags overrun
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done && rbf_q && !data_rd |=> ovr_q);
endmodule

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
  import spi_port_pkg::*;
  localparam int CLK_NS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  wire  [7:0] bus_rdata;
  wire        irq, sck_o, sck_oe, sdo, sdo_oe;
  logic       sck_drv = 1'b0, ss_n = 1'b1;
  logic [7:0] tb_sh = '0, tb_rx = '0;
  logic       tb_idle = 1'b0;
  wire        sdi = tb_sh[7];

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_i(sck_drv),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  typedef struct { logic [7:0] val; bit care; } exp_t;
  exp_t sb_q[$];
  realtime t_first, t_last;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  function automatic logic [7:0] cw(input logic [2:0] rate, input logic edg, input logic go);
    return {3'b000, rate, edg, go};
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(ADR_STAT, s);
      if (!s[SB_BUSY]) break;
    end
  endtask

  // driver: master transfer, bench plays the far end following sck_o
  task automatic master_xfer(input logic [2:0] rate, input logic edg, input logic [7:0] dut_tx,
                             input logic [7:0] far_tx, input bit write_data, input bit poke);
    logic [7:0] s;
    reg_wr(ADR_CTRL, cw(rate, edg, 1'b0));
    if (write_data) reg_wr(ADR_DATA, dut_tx);
    tb_idle = edg; tb_sh = far_tx; tb_rx = '0;
    sb_q.push_back('{dut_tx, 1'b1});
    reg_wr(ADR_CTRL, cw(rate, edg, 1'b1));
    for (int e = 0; e < 16; e++) begin
      @(sck_o);
      if (e == 0) t_first = $realtime;
      t_last = $realtime;
      if (sck_o !== tb_idle) tb_rx = {tb_rx[6:0], sdo};
      else                   tb_sh = {tb_sh[6:0], 1'b0};
      if (poke && e == 2) begin
        reg_rd(ADR_STAT, s);
        chk("R2 busy during transfer", 16'(s[SB_BUSY]), 16'd1);
        reg_wr(ADR_DATA, 8'h3C);
        reg_wr(ADR_CTRL, cw(3'd3, 1'b1, 1'b1));
      end
    end
    wait_idle();
  endtask

  // bench as master clocking a slave-mode port
  task automatic slave_edges(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (8) @(posedge clk);
      #1 sck_drv = ~sck_drv;
      if (sck_drv !== tb_idle) tb_rx = {tb_rx[6:0], sdo};
      else                     tb_sh = {tb_sh[6:0], 1'b0};
    end
  endtask

  // monitor: each completion pops one expected byte seen by the far end
  initial begin
    exp_t e;
    forever begin
      @(posedge irq);
      #1;
      if (sb_q.size() == 0) chk("R1 unexpected completion", 16'd1, 16'd0);
      else begin
        e = sb_q.pop_front();
        if (e.care) chk("R1 byte on sdo msb first", 16'(tb_rx), 16'(e.val));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 16'd1, 16'd0);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    reg_rd(ADR_CTRL, d); chk("R11 ctrl after reset", 16'(d), 16'h00);
    reg_rd(ADR_STAT, d); chk("R11 stat after reset", 16'(d), 16'h00);
    chk("R11 sck_o low", 16'(sck_o), 16'd0);
    chk("R11 irq low", 16'(irq), 16'd0);
    chk("R7 master drives sck", 16'(sck_oe), 16'd1);

    // rate 0, edge 0
    master_xfer(3'd0, 1'b0, 8'hA5, 8'h3C, 1, 0);
    chk("R6 span rate0", 16'(int'((t_last - t_first) / CLK_NS)), 16'(15 * 1));
    reg_rd(ADR_STAT, d); chk("R3 flags set", 16'(d), 16'h03);
    chk("R3 irq pin", 16'(irq), 16'd1);
    reg_rd(ADR_DATA, d); chk("R1 received byte", 16'(d), 16'h3C);
    reg_rd(ADR_STAT, d); chk("R4 full cleared by read", 16'(d), 16'h02);
    reg_wr(ADR_STAT, 8'h00);
    chk("R10 irq cleared by write", 16'(irq), 16'd0);

    // rate 2, edge 1
    master_xfer(3'd2, 1'b1, 8'h5A, 8'hC3, 1, 0);
    chk("R6 span rate2", 16'(int'((t_last - t_first) / CLK_NS)), 16'(15 * 4));
    chk("R8 idle high after transfer", 16'(sck_o), 16'd1);
    reg_rd(ADR_DATA, d); chk("R1 received byte edge1", 16'(d), 16'hC3);
    reg_wr(ADR_STAT, 8'h00);

    // rate 6 with writes during the transfer
    master_xfer(3'd6, 1'b0, 8'h81, 8'h7E, 1, 1);
    chk("R6 span rate6", 16'(int'((t_last - t_first) / CLK_NS)), 16'(15 * 64));
    reg_rd(ADR_CTRL, d); chk("R2 ctrl write during transfer ignored", 16'(d), 16'(cw(3'd6, 1'b0, 1'b0)));
    chk("R8 idle low after transfer", 16'(sck_o), 16'd0);
    reg_rd(ADR_DATA, d); chk("R1 received byte rate6", 16'(d), 16'h7E);
    reg_wr(ADR_STAT, 8'h00);
    master_xfer(3'd1, 1'b0, 8'h81, 8'h00, 0, 0);   // R5: buffer kept 81, not 3C
    reg_rd(ADR_DATA, d); chk("R5 received byte", 16'(d), 16'h00);
    reg_wr(ADR_STAT, 8'h00);

    // overrun
    master_xfer(3'd0, 1'b0, 8'h11, 8'h22, 1, 0);
    reg_wr(ADR_STAT, 8'h04);
    reg_rd(ADR_STAT, d); chk("R10 irq cleared, full kept", 16'(d), 16'h01);
    master_xfer(3'd0, 1'b0, 8'h33, 8'h44, 1, 0);
    reg_rd(ADR_STAT, d); chk("R10 overrun set", 16'(d), 16'h07);
    reg_wr(ADR_STAT, 8'h04);
    reg_rd(ADR_STAT, d); chk("R10 overrun kept by bit2=1", 16'(d), 16'h05);
    reg_rd(ADR_DATA, d); chk("R10 buffer overwritten", 16'(d), 16'h44);
    reg_wr(ADR_STAT, 8'h00);
    reg_rd(ADR_STAT, d); chk("R10 overrun cleared", 16'(d), 16'h00);

    // slave, edge 1
    reg_wr(ADR_CTRL, cw(3'd7, 1'b1, 1'b0));
    tb_idle = 1'b1; sck_drv = 1'b1;
    #1 chk("R7 slave releases sck", 16'(sck_oe), 16'd0);
    chk("R9 sdo floats when deselected", 16'(sdo_oe), 16'd0);
    ss_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 chk("R9 sdo driven when selected", 16'(sdo_oe), 16'd1);
    reg_wr(ADR_DATA, 8'h96);
    tb_sh = 8'h69; tb_rx = '0;
    sb_q.push_back('{8'h96, 1'b1});
    reg_wr(ADR_CTRL, cw(3'd7, 1'b1, 1'b1));
    slave_edges(16);
    wait_idle();
    reg_rd(ADR_DATA, d); chk("R7 slave received byte", 16'(d), 16'h69);
    reg_rd(ADR_STAT, d); chk("R4 slave full cleared", 16'(d), 16'h02);
    reg_wr(ADR_STAT, 8'h00);

    // slave, edge 0, deselect mid-byte restarts the count
    reg_wr(ADR_CTRL, cw(3'd7, 1'b0, 1'b0));
    tb_idle = 1'b0; sck_drv = 1'b0;
    repeat (4) @(posedge clk);
    reg_wr(ADR_DATA, 8'h0F);
    tb_sh = '0; tb_rx = '0;
    sb_q.push_back('{8'h00, 1'b0});
    reg_wr(ADR_CTRL, cw(3'd7, 1'b0, 1'b1));
    slave_edges(6);
    ss_n = 1'b1;
    repeat (8) @(posedge clk);
    ss_n = 1'b0;
    repeat (8) @(posedge clk);
    slave_edges(10);
    repeat (6) @(posedge clk);
    reg_rd(ADR_STAT, d); chk("R9 count restarted, still busy", 16'(d), 16'h08);
    slave_edges(6);
    wait_idle();
    reg_rd(ADR_STAT, d); chk("R9 byte done after 8 fresh bits", 16'(d), 16'h03);
    reg_rd(ADR_DATA, d);
    reg_wr(ADR_STAT, 8'h00);

    repeat (10) @(posedge clk);
    chk("R3 every transfer completed", 16'(sb_q.size()), 16'd0);
    finish_run();
  end
endmodule